// File: doc/BRIEF.md
# Core Rail Low-Voltage Sleep Interlock

This block watches a digital flag from a comparator that reports when the processor core rail has fallen below its programmed low limit. In S3 and S5 sleep states the core rail is dropped on purpose. Temperature-based control loops would then react to the cooling that follows. The interlock suspends those loops for as long as the rail stays low.

When the interlock is enabled and the rail goes low, three things happen. The block records the event in a sticky status bit and raises an alert if alerts are allowed. It also drives three gating outputs to neighbouring blocks:
- freeze the thermal-throttle timer at its current count,
- stop the dynamic minimum-temperature adjustment,
- inhibit entry into the shutdown state.

All three gates drop by themselves once the rail is back above its limit. Software clears the status bit, and the alert with it, through a read strobe from the register port. The analog measurement and the limit compare are done elsewhere.

Top module: `rail_sleep_lock`

## Requirements
- R1: After reset every output (`lo_status`, `alert`, `timer_hold`, `dyn_adj_off`, `shdn_block`) is 0.
- R2: `rail_low` is synchronized by two flops before use. A level sampled at one rising clock edge reaches the gating outputs at the third rising edge counted from that one, and not earlier.
- R3: While `lo_mon_en` is 1 and the synchronized rail-low flag is 1, `timer_hold` is 1.
- R4: Under the same condition as R3, `dyn_adj_off` is 1.
- R5: Under the same condition as R3, `shdn_block` is 1.
- R6: `lo_status` is set in the same cycle the gating outputs rise (entry into the low condition). It stays set after the rail recovers until it is read.
- R7: A cycle with `stat_rd` = 1 clears `lo_status` and `alert` at the next edge. If the rail is still low, neither reasserts until a new entry. A new entry in the same cycle as a read wins over the clear.
- R8: `alert` is set at entry only if `alert_en` is 1 in that cycle. Otherwise no alert appears for that episode.
- R9: When the synchronized flag returns to 0, all three gating outputs return to 0 at the same edge.
- R10: With `lo_mon_en` = 0, the gating outputs and `lo_status` stay 0 whatever `rail_low` reports.
- R11: Clearing `lo_mon_en` while the rail is low drops the gating outputs at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_mon_en | input | 1 | Control-register enable for the interlock |
| alert_en | input | 1 | Allows the alert output for low-rail events |
| rail_low | input | 1 | Asynchronous comparator flag, 1 = core rail below limit |
| stat_rd | input | 1 | Status read strobe, clears the sticky status and alert |
| lo_status | output | 1 | Sticky low-rail status bit |
| alert | output | 1 | Alert request, active high |
| timer_hold | output | 1 | Freezes the thermal-throttle timer |
| dyn_adj_off | output | 1 | Disables dynamic minimum-temperature adjustment |
| shdn_block | output | 1 | Prevents entry into shutdown |

## Verification
The hardest case is a status read that arrives while the rail is still low. A read there must clear the bit for good, and the bit may come back only after a new entry. The bench holds the rail low, strobes the read a few cycles after entry, and checks that status stays clear while the gates stay up. It then toggles the enable to force a fresh entry in the same cycle as a second read, so the set-over-clear priority is exercised at the port edge.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;

  typedef struct packed {
    logic hold;
    logic adj_off;
    logic block;
  } gate_t;
endpackage

// File: rtl/rsl_sync.sv
module rsl_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[LAST-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/rsl_flags.sv
module rsl_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic entry,
  input  logic alert_en,
  input  logic rd,
  output logic status,
  output logic alert
);
  logic status_q, status_d;
  logic alert_q, alert_d;

  always_comb begin
    status_d = status_q;
    alert_d  = alert_q;
    if (rd) begin
      status_d = 1'b0;
      alert_d  = 1'b0;
    end
    if (entry) begin
      status_d = 1'b1;
      alert_d  = alert_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      alert_q  <= alert_d;
    end
  end

  assign status = status_q;
  assign alert  = alert_q;

  assert_alert_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alert_q |-> status_q);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !entry) |=> (!status_q && !alert_q));
  assert_entry_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> status_q);
endmodule

// File: rtl/rail_sleep_lock.sv
module rail_sleep_lock
  import rsl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo_mon_en,
  input  logic alert_en,
  input  logic rail_low,
  input  logic stat_rd,
  output logic lo_status,
  output logic alert,
  output logic timer_hold,
  output logic dyn_adj_off,
  output logic shdn_block
);
  logic  rst_n_s;
  logic  low_s;
  logic  active_d;
  logic  entry;
  gate_t gate_q, gate_d;

  rsl_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  rsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_low (
    .clk(clk), .rst_n(rst_n_s), .d(rail_low), .q(low_s)
  );

  always_comb begin
    active_d        = lo_mon_en & low_s;
    entry           = active_d & ~gate_q.hold;
    gate_d.hold     = active_d;
    gate_d.adj_off  = active_d;
    gate_d.block    = active_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) gate_q <= '0;
    else          gate_q <= gate_d;
  end

  rsl_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .entry(entry), .alert_en(alert_en),
    .rd(stat_rd), .status(lo_status), .alert(alert)
  );

  assign timer_hold  = gate_q.hold;
  assign dyn_adj_off = gate_q.adj_off;
  assign shdn_block  = gate_q.block;

  assert_disable_drops_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lo_mon_en |=> (!timer_hold && !dyn_adj_off && !shdn_block));
  assert_gates_agree_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (timer_hold == dyn_adj_off) && (timer_hold == shdn_block));
  assert_status_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(lo_status) |-> $rose(timer_hold));
  assert_enable_needed_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(timer_hold) |-> $past(lo_mon_en));
endmodule

// File: tb/tb_rail_sleep_lock.sv
`timescale 1ns/1ps
module tb_rail_sleep_lock;
  logic clk = 1'b0;
  logic rst_n, lo_mon_en, alert_en, rail_low, stat_rd;
  logic lo_status, alert, timer_hold, dyn_adj_off, shdn_block;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rail_sleep_lock dut (
    .clk(clk), .rst_n(rst_n), .lo_mon_en(lo_mon_en), .alert_en(alert_en),
    .rail_low(rail_low), .stat_rd(stat_rd), .lo_status(lo_status),
    .alert(alert), .timer_hold(timer_hold), .dyn_adj_off(dyn_adj_off),
    .shdn_block(shdn_block)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {lo_status, alert, timer_hold, dyn_adj_off, shdn_block};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {status,alert,hold,adj,block} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; lo_mon_en = 1'b0; alert_en = 1'b0; rail_low = 1'b0; stat_rd = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1", 5'b00000);
  endtask

  task automatic t_latency_and_entry;
    lo_mon_en = 1'b1; alert_en = 1'b1;
    rail_low = 1'b1;
    step(2);
    chk("R2", 5'b00000);
    step(1);
    chk("R2 R3 R4 R5 R6 R8", 5'b11111);
  endtask

  task automatic t_recover_sticky;
    rail_low = 1'b0;
    step(2);
    chk("R2 R6", 5'b11111);
    step(1);
    chk("R9 R6", 5'b11000);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R7", 5'b00000);
  endtask

  task automatic t_read_while_low;
    rail_low = 1'b1; step(3);
    chk("R6 R8", 5'b11111);
    step(2);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R7", 5'b00111);
    step(4);
    chk("R7", 5'b00111);
    lo_mon_en = 1'b0; step(1);
    chk("R11", 5'b00000);
    lo_mon_en = 1'b1; stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R7", 5'b11111);
    rail_low = 1'b0; step(3);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R7 R9", 5'b00000);
  endtask

  task automatic t_no_alert;
    alert_en = 1'b0; rail_low = 1'b1; step(3);
    chk("R8", 5'b10111);
    alert_en = 1'b1; step(2);
    chk("R8", 5'b10111);
    rail_low = 1'b0; step(3);
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    chk("R8", 5'b00000);
  endtask

  task automatic t_disabled;
    lo_mon_en = 1'b0; rail_low = 1'b1;
    step(6);
    chk("R10", 5'b00000);
    rail_low = 1'b0; step(2); rail_low = 1'b1; step(5);
    chk("R10", 5'b00000);
    rail_low = 1'b0; step(3);
    chk("R10", 5'b00000);
  endtask

  initial begin
    t_reset();
    t_latency_and_entry();
    t_recover_sticky();
    t_read_while_low();
    t_no_alert();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule